// File: doc/BRIEF.md
# Clock-Configuration Register Slave on a Two-Wire Serial Bus

This block is a serial-bus target that lets a host set up a clock generator. It stores per-output stop bits, a frequency-select override and a spread-spectrum enable. The bank is a few eight-bit registers, and all of them are presented as one parallel vector for the clock logic to decode. The bus wires are oversampled by the system clock. SDA is driven open-drain through an output-enable that pulls the line low.

A write transfer works as follows. The block recognises its fixed address with the direction bit low. It then acknowledges and throws away two leading bytes: a command code and a byte count. Each byte after those lands in the next register, starting at register 0.

A read transfer works as follows. The block first returns the number of registers, then the registers in order. Past the end of the bank it returns all-ones until the host answers with a NACK. A START or STOP on the bus always returns the byte engine to a known state.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset every register holds 0x00 (cfg_o is all zero) and SDA is released (sda_oe low).
- R2: Only the 7-bit address 0x69 is answered. A first byte of 0xD2 selects write and 0xD3 selects read. Any other address is not acknowledged and changes no register.
- R3: In a write, the two bytes that follow the address are acknowledged and leave every register unchanged.
- R4: In a write, the third and later bytes go to register 0, 1, 2 and so on in turn. Register k appears on cfg_o bits [8k+7:8k].
- R5: The slave acknowledges every byte of an addressed transfer by holding SDA low through the ninth SCL pulse.
- R6: A STOP after any number of data bytes, including none, ends the write. Registers that were not reached keep their values.
- R7: Data bytes beyond the last register are acknowledged and discarded.
- R8: In a read, the first byte returned is the register count, 6, as a plain binary value.
- R9: After the count, a read returns register 0, 1, 2 and so on. Any byte past the last register reads as 0xFF. Bytes are sent MSB first.
- R10: When the master NACKs a read byte, the slave releases SDA and drives nothing more until the next START.
- R11: A START at any point, including in the middle of a byte, restarts address reception. The transfer that follows behaves normally.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_o | output | 48 | Register bank, register k in bits [8k+7:8k] |

## Verification
The bench targets the two dummy bytes. A design that counted only one would shift every register by one position. A design that counted none would overwrite register 0 with the command code. Overflow writes are also exercised: a design without the guard would wrap or corrupt the bank. Reads run past the end of the bank to check both the leading count and the 0xFF fill. A missing count would return every register one byte early. A START is injected halfway through a byte to catch a bit counter that is not cleared and would misalign the next address. After a master NACK, the bench watches that SDA stays free. A slave that kept shifting would pull the line low and block the STOP.

// File: rtl/clkcfg_pkg.sv
// Shared types for the clock-configuration bus slave.
package clkcfg_pkg;
    // Byte-engine states of the slave.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // no transfer for us
        ST_RX    = 3'd1,  // shifting in address or write data
        ST_ACKW  = 3'd2,  // byte taken, waiting for SCL low to acknowledge
        ST_ACK   = 3'd3,  // holding SDA low for the ninth clock
        ST_TX    = 3'd4,  // shifting out a read byte
        ST_TXACK = 3'd5,  // SDA released, sampling master acknowledge
        ST_TXNXT = 3'd6,  // master acknowledged, load next byte at SCL fall
        ST_WAIT  = 3'd7   // ignore the bus until START or STOP
    } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises the bus lines into the clk domain and flags SCL edges plus
// START/STOP conditions. Assumes the bus is idle-high and that each SCL
// phase lasts several clk cycles.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Metastability chains, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/clkcfg_regbank.sv
// Bank of NREG eight-bit configuration registers with one write port and
// one read port. A read index past the bank returns all-ones.
module clkcfg_regbank #(
    parameter int NREG = 6,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [7:0]      rd_data,
    output logic [NREG*8-1:0] cfg_o
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Register g loads when the write index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= 8'h00;
            else if (wr_en && wr_idx == IDXW'(g))
                regs[g] <= wr_data;
        end
        assign cfg_o[g*8 +: 8] = regs[g];
    end

    // Read mux with all-ones fill beyond the last register.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDXW'(i))
                rd_data = regs[i];
    end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
// Bus target for clock-generator configuration. Write: address, two
// discarded bytes, then data into successive registers. Read: register
// count, then registers, then 0xFF. Assumes no clock stretching is needed
// and that SCL phases are much longer than the synchroniser delay.
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int         NREG     = 6,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int IDXW = $clog2(NREG + 3);
    localparam logic [IDXW-1:0] IDX_SAT   = IDXW'(NREG + 2);
    localparam logic [IDXW-1:0] FIRST_DAT = IDXW'(2);
    localparam logic [7:0]      REG_COUNT = 8'(NREG);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    slv_state_t      state;
    logic [2:0]      bit_cnt;
    logic [7:0]      rx_sh;
    logic [7:0]      tx_sh;
    logic            is_read;
    logic            addr_phase;
    logic [IDXW-1:0] byte_idx;

    logic [7:0]      rx_next;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [IDXW-1:0] rd_idx;
    logic [7:0]      rd_data;
    logic [7:0]      tx_byte;
    logic [IDXW-1:0] idx_inc;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_regbank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (rx_next),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

    // Datapath decode: incoming byte, register write strobe, outgoing byte.
    always_comb begin
        rx_next = {rx_sh[6:0], sda_s};
        wr_idx  = byte_idx - FIRST_DAT;
        wr_en   = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7) &&
                  !addr_phase && (byte_idx >= FIRST_DAT) && (byte_idx < IDX_SAT);
        rd_idx  = byte_idx - IDXW'(1);
        tx_byte = (byte_idx == '0) ? REG_COUNT : rd_data;
        idx_inc = (byte_idx == IDX_SAT) ? byte_idx : byte_idx + IDXW'(1);
    end

    // Byte engine: framing, acknowledge timing and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '1;
            is_read    <= 1'b0;
            addr_phase <= 1'b0;
            byte_idx   <= '0;
        end else if (start_det) begin
            state      <= ST_RX;
            bit_cnt    <= '0;
            is_read    <= 1'b0;
            addr_phase <= 1'b1;
            byte_idx   <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_RX: if (scl_rise) begin
                    rx_sh   <= rx_next;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        if (addr_phase) begin
                            if (rx_next[7:1] == DEV_ADDR) begin
                                is_read <= rx_next[0];
                                state   <= ST_ACKW;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else begin
                            byte_idx <= idx_inc;
                            state    <= ST_ACKW;
                        end
                    end
                end
                ST_ACKW: if (scl_fall) state <= ST_ACK;
                ST_ACK: if (scl_fall) begin
                    addr_phase <= 1'b0;
                    bit_cnt    <= '0;
                    if (is_read) begin
                        tx_sh    <= tx_byte;
                        byte_idx <= idx_inc;
                        state    <= ST_TX;
                    end else begin
                        state <= ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    tx_sh   <= {tx_sh[6:0], 1'b1};
                    if (bit_cnt == 3'd7) state <= ST_TXACK;
                end
                ST_TXACK: if (scl_rise) state <= sda_s ? ST_WAIT : ST_TXNXT;
                ST_TXNXT: if (scl_fall) begin
                    tx_sh    <= tx_byte;
                    bit_cnt  <= '0;
                    byte_idx <= idx_inc;
                    state    <= ST_TX;
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !tx_sh[7]);
endmodule

// File: rtl/clkcfg_i2c_checker.sv
// Protocol assertions for clkcfg_i2c_slave, attached with bind below.
module clkcfg_i2c_checker
    import clkcfg_pkg::*;
#(
    parameter int NREG = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              sda_s,
    input logic              start_det,
    input logic              stop_det,
    input slv_state_t        state,
    input logic [2:0]        bit_cnt,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_o
);
    AST_CFG_ON_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(scl_rise)) else $error("cfg moved off edge"); // R4

    AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACKW && scl_fall && !start_det && !stop_det) |=> sda_oe) else $error("no ack"); // R5

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXACK && scl_rise && sda_s) |=> !sda_oe) else $error("drive after nack"); // R10

    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && bit_cnt == 3'd0)) else $error("start not rearmed"); // R11

    AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)) else $error("oe moved"); // R12
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (state),
    .bit_cnt   (bit_cnt),
    .sda_oe    (sda_oe),
    .cfg_o     (cfg_o)
);

// File: tb/clkcfg_i2c_slave_bench.sv
// Bench: drives the bus as a master, keeps a behavioural register model and
// compares cfg_o against it on every clock.
module clkcfg_i2c_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 6;
    localparam int HALF       = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_line;
    logic              sda_oe;
    logic [NREG*8-1:0] cfg_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  hold    = 1'b1;
    bit  done    = 1'b0;
    logic [7:0] mdl [NREG];
    logic [NREG*8-1:0] exp_cfg;
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    clkcfg_i2c_slave #(.NREG(NREG)) u_clkcfg_i2c_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .cfg_o  (cfg_o)
    );

    always_comb
        for (int k = 0; k < NREG; k++) exp_cfg[k*8 +: 8] = mdl[k];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R4, R6) and drive timing (R12).
    always @(negedge clk) begin
        if (rst_n && !hold && !done) begin
            chk(cfg_o == exp_cfg, "R4/R6", "cfg_o vs model", cfg_o, exp_cfg);
            if (prev_scl && scl_m && (prev_oe != sda_oe))
                chk(1'b0, "R12", "sda_oe moved with SCL high", sda_oe, prev_oe);
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b0; wclk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b1; wclk(HALF);
    endtask

    // Sends one byte; st_idx >= 0 updates the model once the last bit is in.
    task automatic send_byte(input logic [7:0] b, input int st_idx, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(HALF);
            if (i == 0) begin
                hold = 1'b1;
                scl_m = 1'b1; wclk(8);
                if (st_idx >= 0 && st_idx < NREG) mdl[st_idx] = b;
                hold = 1'b0;
                wclk(HALF - 8);
            end else begin
                scl_m = 1'b1; wclk(HALF);
            end
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF/2);
        acked = !sda_line;
        wclk(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(HALF);
            scl_m = 1'b1; wclk(HALF/2);
            b[i] = sda_line;
            wclk(HALF/2);
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        scl_m = 1'b0; wclk(2);
        sda_m = 1'b1;
    endtask

    // Write: address, two dummies, then data bytes; all acks checked.
    task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt,
                            input logic [7:0] dat [$]);
        logic a;
        bus_start();
        send_byte(8'hD2, -1, a);
        chk(a, "R2", "write address ack", a, 1);
        send_byte(cmd, -1, a);
        chk(a, "R3", "command byte ack", a, 1);
        send_byte(cnt, -1, a);
        chk(a, "R3", "count byte ack", a, 1);
        chk(cfg_o == exp_cfg, "R3", "dummies leave bank", cfg_o, exp_cfg);
        foreach (dat[i]) begin
            send_byte(dat[i], i, a);
            chk(a, (i < NREG) ? "R5" : "R7", "data byte ack", a, 1);
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] rb;
        logic [7:0] q [$];
        for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        chk(cfg_o == '0, "R1", "reset bank", cfg_o, 0);
        chk(sda_oe == 1'b0, "R1", "reset sda released", sda_oe, 0);
        hold = 1'b0;

        // R4: three data bytes land in registers 0..2.
        q = '{8'h11, 8'h22, 8'h33};
        do_write(8'hA5, 8'h33, q);
        chk(cfg_o[23:0] == 24'h332211, "R4", "first three registers", cfg_o[23:0], 24'h332211);

        // R6: zero data bytes, nothing changes.
        q = {};
        do_write(8'h00, 8'h00, q);

        // R7: eight data bytes, last two discarded.
        q = '{8'h01, 8'h82, 8'h43, 8'hC4, 8'h25, 8'hA6, 8'hEE, 8'h77};
        do_write(8'h5A, 8'h08, q);

        // R6: partial write keeps the upper registers.
        q = '{8'h9C};
        do_write(8'h00, 8'h01, q);
        chk(cfg_o[47:8] == {8'hA6, 8'h25, 8'hC4, 8'h43, 8'h82}, "R6", "upper registers kept",
            cfg_o[47:8], {8'hA6, 8'h25, 8'hC4, 8'h43, 8'h82});

        // R2: foreign address is not acknowledged; following bytes ignored.
        bus_start();
        send_byte(8'hA0, -1, a);
        chk(!a, "R2", "foreign address nack", a, 0);
        send_byte(8'hFF, -1, a);
        chk(!a, "R2", "byte after foreign address nack", a, 0);
        bus_stop();

        // R8, R9, R10: read count, registers, fill, then NACK.
        bus_start();
        send_byte(8'hD3, -1, a);
        chk(a, "R2", "read address ack", a, 1);
        for (int i = 0; i < NREG + 3; i++) begin
            logic [7:0] e;
            e = (i == 0) ? 8'(NREG) : ((i <= NREG) ? mdl[i-1] : 8'hFF);
            recv_byte(i != NREG + 2, rb);
            chk(rb == e, (i == 0) ? "R8" : "R9", "read byte", rb, e);
        end
        for (int i = 0; i < 3 * HALF; i++) begin
            if (i % 10 == 0) begin
                scl_m = ~scl_m;
            end
            if (sda_oe) begin
                chk(1'b0, "R10", "drive after nack", sda_oe, 0);
                break;
            end
            wclk(1);
        end
        scl_m = 1'b0; wclk(HALF);
        chk(sda_oe == 1'b0, "R10", "released after nack", sda_oe, 0);
        bus_stop();

        // R11: START in the middle of a byte, then a normal write.
        bus_start();
        for (int i = 7; i >= 4; i--) begin
            sda_m = (i % 2 == 0); wclk(HALF);
            scl_m = 1'b1; wclk(HALF);
            scl_m = 1'b0;
        end
        q = '{8'h5A, 8'h3C};
        do_write(8'h11, 8'h02, q);
        chk(cfg_o[15:0] == 16'h3C5A, "R11", "write after mid-byte start", cfg_o[15:0], 16'h3C5A);

        wclk(10);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule